// File: doc/BRIEF.md
# Texture Gather Unit

This block takes one gather request (a normalised sample position in fixed point, the texture dimensions, a channel select and an optional depth comparison) and collects the 2x2 group of texels that a bilinear filter would blend at that position. From each of the four texels it keeps one scalar channel and packs the four scalars into a single result word. Filter weights are never computed. The caller receives the raw corner values, or pass/fail flags when comparison is enabled, and applies its own arithmetic.

Texels come from an external synchronous memory that holds one 4-channel word per texel, stored row by row. The unit issues the four reads back to back on its read port. Each result element is formed as the data returns. The finished word is then presented on a valid/ready result port. The request port is valid/ready as well. It accepts one request only while the unit is idle, so a new request waits until the previous result has been taken. Holding `res_ready` low stalls the unit with its result frozen and blocks further requests. The unit never drops a result.

Top module: `gather_unit`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` is 0 and `rd_en` is 0.
- R2: With `req_u`/`req_v` unsigned fixed point holding UV_FRAC fraction bits, the footprint origin is i = floor(u*W - 0.5) and j = floor(v*H - 0.5). W and H are `req_w`/`req_h`, each at least 1.
- R3: Each of the columns i and i+1 is clamped to [0, W-1], and each of the rows j and j+1 is clamped to [0, H-1], before addressing.
- R4: The address of texel (x, y) is y*W + x.
- R5: Reads and result elements follow this corner order. Element 0 (bits [CH_W-1:0]) is (i, j+1). Element 1 is (i+1, j+1). Element 2 is (i+1, j). Element 3 (the top bits) is (i, j).
- R6: `req_chan` selects the field of the texel word. 0 is red, bits [CH_W-1:0]. 1 is green, the next CH_W bits. 2 is blue. 3 is alpha, the top CH_W bits.
- R7: When `req_cmp_en` is 1, an element is all ones if `req_cmp_ref` <= the selected channel value, and 0 otherwise.
- R8: The four reads occupy four consecutive cycles, starting in the cycle after the request is accepted. Read data is expected one cycle after `rd_en`. `res_valid` first samples high at the fifth rising edge after the accepting edge.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` is unchanged. `req_ready` and `res_valid` are never 1 together.
- R10: A request presented while the unit is busy is not taken. It starts no reads and leaves the pending result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_u | input | UV_W | Horizontal position, UV_FRAC fraction bits |
| req_v | input | UV_W | Vertical position, UV_FRAC fraction bits |
| req_w | input | DIM_W | Texture width in texels |
| req_h | input | DIM_W | Texture height in texels |
| req_chan | input | 2 | Channel select |
| req_cmp_en | input | 1 | Comparison mode |
| req_cmp_ref | input | CH_W | Comparison reference depth |
| rd_en | output | 1 | Texel read strobe |
| rd_addr | output | 2*(DIM_W-1) | Texel address |
| rd_data | input | 4*CH_W | Texel word, one cycle after rd_en |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted by the consumer |
| res_data | output | 4*CH_W | Four packed elements |

## Verification
The bench uses the defaults: UV_W=12 with UV_FRAC=10, DIM_W=5 (textures up to 16x16) and CH_W=8. These values make every clamp edge reachable with small textures. Among them are negative origins at u=0, positions past 1.0 and 1x1 textures where all four corners collapse onto one texel. They also make the exact equality case of the comparison easy to hit. Since the memory model's texel words are a function of the address, each channel value and each read address can be predicted from the corner order alone.

// File: rtl/gather_pkg.sv
package gather_pkg;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_ALPHA = 2'd3
  } chan_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

  localparam int CORNERS = 4;

  // Corner k uses column i+1 when this is set.
  function automatic logic corner_right(input logic [1:0] k);
    return (k == 2'd1) || (k == 2'd2);
  endfunction

  // Corner k uses row j+1 (the lower row) when this is set.
  function automatic logic corner_lower(input logic [1:0] k);
    return (k == 2'd0) || (k == 2'd1);
  endfunction

endpackage

// File: rtl/gather_axis_origin.sv
module gather_axis_origin #(
  parameter int UV_W    = 12,
  parameter int UV_FRAC = 10,
  parameter int DIM_W   = 5,
  localparam int IDX_W  = DIM_W - 1
) (
  input  logic [UV_W-1:0]  coord,
  input  logic [DIM_W-1:0] dim,
  output logic [IDX_W-1:0] lo,
  output logic [IDX_W-1:0] hi
);

  localparam int PW = UV_W + DIM_W + 2;

  logic [PW-1:0]        scaled;
  logic signed [PW-1:0] centred;
  logic signed [PW-1:0] base;
  logic signed [PW-1:0] base_next;
  logic signed [PW-1:0] last;

  function automatic logic [IDX_W-1:0] clip(input logic signed [PW-1:0] t,
                                            input logic signed [PW-1:0] top);
    if (t < 0)        return '0;
    else if (t > top) return IDX_W'(top);
    else              return IDX_W'(t);
  endfunction

  always_comb begin
    scaled    = PW'(coord) * PW'(dim);
    centred   = $signed(scaled) - $signed(PW'(1) << (UV_FRAC - 1));
    base      = centred >>> UV_FRAC;
    base_next = base + 1;
    last      = $signed(PW'(dim)) - 1;
    lo        = clip(base, last);
    hi        = clip(base_next, last);
  end

endmodule

// File: rtl/gather_texel_pick.sv
module gather_texel_pick
  import gather_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int WORD_W = 4 * CH_W
) (
  input  logic [WORD_W-1:0] word,
  input  chan_e             chan,
  input  logic              cmp_en,
  input  logic [CH_W-1:0]   cmp_ref,
  output logic [CH_W-1:0]   elem
);

  logic [CH_W-1:0] lane [4];
  logic [CH_W-1:0] picked;

  for (genvar c = 0; c < 4; c++) begin : g_lane
    assign lane[c] = word[c*CH_W +: CH_W];
  end

  always_comb begin
    picked = lane[chan];
    if (cmp_en) elem = (cmp_ref <= picked) ? '1 : '0;
    else        elem = picked;
  end

endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gather_pkg::*;
#(
  parameter int DIM_W  = 5,
  localparam int IDX_W  = DIM_W - 1,
  localparam int ADDR_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              res_fire,
  input  logic [IDX_W-1:0]  x_lo,
  input  logic [IDX_W-1:0]  x_hi,
  input  logic [IDX_W-1:0]  y_lo,
  input  logic [IDX_W-1:0]  y_hi,
  input  logic [DIM_W-1:0]  tex_w,
  output logic              idle,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_en,
  output logic [1:0]        cap_slot
);

  seq_state_e       st;
  logic [1:0]       corner;
  logic [IDX_W-1:0] xl_q, xh_q, yl_q, yh_q;
  logic [DIM_W-1:0] w_q;
  logic [IDX_W-1:0] cur_x, cur_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      corner   <= '0;
      xl_q     <= '0;
      xh_q     <= '0;
      yl_q     <= '0;
      yh_q     <= '0;
      w_q      <= '0;
      cap_en   <= 1'b0;
      cap_slot <= '0;
    end else begin
      cap_en   <= (st == ST_FETCH);
      cap_slot <= corner;
      unique case (st)
        ST_IDLE: if (start) begin
          xl_q   <= x_lo;
          xh_q   <= x_hi;
          yl_q   <= y_lo;
          yh_q   <= y_hi;
          w_q    <= tex_w;
          corner <= '0;
          st     <= ST_FETCH;
        end
        ST_FETCH: begin
          corner <= corner + 2'd1;
          if (corner == 2'(CORNERS - 1)) st <= ST_DRAIN;
        end
        ST_DRAIN: st <= ST_HOLD;
        ST_HOLD:  if (res_fire) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cur_x   = corner_right(corner) ? xh_q : xl_q;
    cur_y   = corner_lower(corner) ? yh_q : yl_q;
    rd_addr = ADDR_W'(ADDR_W'(cur_y) * ADDR_W'(w_q)) + ADDR_W'(cur_x);
    rd_en   = (st == ST_FETCH);
    idle    = (st == ST_IDLE);
    done    = (st == ST_HOLD);
  end

endmodule

// File: rtl/gather_unit.sv
module gather_unit
  import gather_pkg::*;
#(
  parameter int UV_W    = 12,
  parameter int UV_FRAC = 10,
  parameter int DIM_W   = 5,
  parameter int CH_W    = 8,
  localparam int IDX_W  = DIM_W - 1,
  localparam int ADDR_W = 2 * IDX_W,
  localparam int WORD_W = 4 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [UV_W-1:0]   req_u,
  input  logic [UV_W-1:0]   req_v,
  input  logic [DIM_W-1:0]  req_w,
  input  logic [DIM_W-1:0]  req_h,
  input  logic [1:0]        req_chan,
  input  logic              req_cmp_en,
  input  logic [CH_W-1:0]   req_cmp_ref,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data
);

  logic [UV_W-1:0]  axis_coord [2];
  logic [DIM_W-1:0] axis_dim   [2];
  logic [IDX_W-1:0] axis_lo    [2];
  logic [IDX_W-1:0] axis_hi    [2];

  logic            start, res_fire, idle, done, cap_en;
  logic [1:0]      cap_slot;
  chan_e           chan_q;
  logic            cmp_q;
  logic [CH_W-1:0] ref_q;
  logic [CH_W-1:0] elem;
  logic [CH_W-1:0] res_q [CORNERS];

  assign axis_coord[0] = req_u;
  assign axis_coord[1] = req_v;
  assign axis_dim[0]   = req_w;
  assign axis_dim[1]   = req_h;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    gather_axis_origin #(
      .UV_W(UV_W), .UV_FRAC(UV_FRAC), .DIM_W(DIM_W)
    ) i_axis (
      .coord(axis_coord[a]),
      .dim  (axis_dim[a]),
      .lo   (axis_lo[a]),
      .hi   (axis_hi[a])
    );
  end

  assign start     = req_valid && idle;
  assign res_fire  = done && res_ready;
  assign req_ready = idle;
  assign res_valid = done;

  gather_seq #(.DIM_W(DIM_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .res_fire(res_fire),
    .x_lo    (axis_lo[0]),
    .x_hi    (axis_hi[0]),
    .y_lo    (axis_lo[1]),
    .y_hi    (axis_hi[1]),
    .tex_w   (req_w),
    .idle    (idle),
    .done    (done),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cap_en  (cap_en),
    .cap_slot(cap_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= CH_RED;
      cmp_q  <= 1'b0;
      ref_q  <= '0;
    end else if (start) begin
      chan_q <= chan_e'(req_chan);
      cmp_q  <= req_cmp_en;
      ref_q  <= req_cmp_ref;
    end
  end

  gather_texel_pick #(.CH_W(CH_W)) i_pick (
    .word   (rd_data),
    .chan   (chan_q),
    .cmp_en (cmp_q),
    .cmp_ref(ref_q),
    .elem   (elem)
  );

  for (genvar k = 0; k < CORNERS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             res_q[k] <= '0;
      else if (cap_en && cap_slot == 2'(k))   res_q[k] <= elem;
    end
    assign res_data[k*CH_W +: CH_W] = res_q[k];
  end

endmodule

// File: rtl/gather_unit_checker.sv
module gather_unit_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_en,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_data
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  p_busy_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !req_ready);

  p_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |=> rd_en);

  p_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ($past(rd_en, 2) && !$past(rd_en)));

endmodule

bind gather_unit gather_unit_checker #(.WORD_W(4 * CH_W)) i_gather_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rd_en    (rd_en),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data)
);

// File: tb/test_gather_unit.sv
module test_gather_unit;

  localparam int UV_W = 12, UV_FRAC = 10, DIM_W = 5, CH_W = 8;
  localparam int ADDR_W = 2 * (DIM_W - 1), WORD_W = 4 * CH_W;

  typedef struct packed {
    logic [11:0]       u;
    logic [11:0]       v;
    logic [4:0]        w;
    logic [4:0]        h;
    logic [1:0]        ch;
    logic              cmp;
    logic [7:0]        rf;
    logic signed [7:0] oi;  // expected origin column (R2)
    logic signed [7:0] oj;  // expected origin row (R2)
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{12'd512,  12'd512,  5'd8,  5'd4,  2'd0, 1'b0, 8'd0,   8'sd3,  8'sd1},
    '{12'd0,    12'd0,    5'd8,  5'd4,  2'd1, 1'b0, 8'd0,  -8'sd1, -8'sd1},
    '{12'd1023, 12'd1023, 5'd8,  5'd4,  2'd2, 1'b0, 8'd0,   8'sd7,  8'sd3},
    '{12'd100,  12'd300,  5'd16, 5'd16, 2'd3, 1'b0, 8'd0,   8'sd1,  8'sd4},
    '{12'd512,  12'd256,  5'd8,  5'd8,  2'd0, 1'b1, 8'd12,  8'sd3,  8'sd1},
    '{12'd700,  12'd900,  5'd5,  5'd3,  2'd1, 1'b1, 8'd0,   8'sd2,  8'sd2},
    '{12'd1536, 12'd512,  5'd4,  5'd2,  2'd2, 1'b0, 8'd0,   8'sd5,  8'sd0},
    '{12'd512,  12'd512,  5'd1,  5'd1,  2'd3, 1'b1, 8'hC3,  8'sd0,  8'sd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [UV_W-1:0] req_u = '0, req_v = '0;
  logic [DIM_W-1:0] req_w = 5'd1, req_h = 5'd1;
  logic [1:0] req_chan = '0;
  logic req_cmp_en = 1'b0;
  logic [CH_W-1:0] req_cmp_ref = '0;
  logic rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data = '0;
  logic res_valid, res_ready = 1'b0;
  logic [WORD_W-1:0] res_data;

  int errors = 0, checks = 0;
  int rd_cnt = 0;
  int rd_log [8];

  always #5 clk = ~clk;

  gather_unit i_gather_unit (.*);

  function automatic logic [WORD_W-1:0] texel(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hC3, ~b, 8'(b * 8'd7), b};
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= texel(int'(rd_addr));
      if (rd_cnt < 8) rd_log[rd_cnt] <= int'(rd_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  function automatic int clip(input int t, input int n);
    if (t < 0) return 0;
    if (t > n - 1) return n - 1;
    return t;
  endfunction

  // R5 corner order: (i,j+1), (i+1,j+1), (i+1,j), (i,j)
  function automatic int corner_addr(input vec_t tv, input int k);
    int x, y;
    x = clip(int'(tv.oi) + ((k == 1 || k == 2) ? 1 : 0), int'(tv.w));
    y = clip(int'(tv.oj) + ((k == 0 || k == 1) ? 1 : 0), int'(tv.h));
    return y * int'(tv.w) + x;
  endfunction

  function automatic logic [7:0] exp_elem(input vec_t tv, input int k);
    logic [WORD_W-1:0] wd;
    logic [7:0] c;
    wd = texel(corner_addr(tv, k));
    c = wd[int'(tv.ch)*8 +: 8];
    if (tv.cmp) return (tv.rf <= c) ? 8'hFF : 8'h00;
    return c;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input vec_t tv);
    @(negedge clk);
    req_u = tv.u; req_v = tv.v; req_w = tv.w; req_h = tv.h;
    req_chan = tv.ch; req_cmp_en = tv.cmp; req_cmp_ref = tv.rf;
    req_valid = 1'b1;
    rd_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output int lat);
    lat = 0;
    while (!res_valid && lat < 20) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic take_result();
    @(negedge clk);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int lat;
    vec_t tv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", req_ready, 1);
    check("R1 res_valid", res_valid, 0);
    check("R1 rd_en", rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", req_ready, 1);

    for (int n = 0; n < NV; n++) begin
      tv = VECS[n];
      send(tv);
      wait_result(lat);
      check("R8 latency", lat, 5);
      check("R8 read count", rd_cnt, 4);
      for (int k = 0; k < 4; k++)
        check("R2 R3 R4 R5 address", rd_log[k], corner_addr(tv, k));
      for (int k = 0; k < 4; k++)
        check(tv.cmp ? "R7 R5 element" : "R6 R5 element",
              res_data[k*8 +: 8], exp_elem(tv, k));
      take_result();
      check("R9 released", res_valid, 0);
    end

    // R9 back-pressure and R10 busy request
    tv = VECS[0];
    send(tv);
    wait_result(lat);
    check("R8 latency stalled run", lat, 5);
    @(negedge clk);
    req_u = 12'd0; req_v = 12'd0; req_chan = 2'd3; req_valid = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check("R9 valid held", res_valid, 1);
      check("R10 not ready while busy", req_ready, 0);
    end
    for (int k = 0; k < 4; k++)
      check("R9 R10 data held", res_data[k*8 +: 8], exp_elem(tv, k));
    check("R10 no extra reads", rd_cnt, 4);
    req_valid = 1'b0;
    take_result();
    repeat (8) @(negedge clk);
    check("R10 no late start", rd_cnt, 4);
    check("R10 stays idle", res_valid, 0);
    check("R1 ready again", req_ready, 1);

    finish_run();
  end

endmodule